// File: doc/BRIEF.md
# Multi-Standard 1-D Inverse Integer Transform

This block turns one row or one column of decoded transform coefficients back into spatial samples. It serves three video coding standards. A mode input selects the standard, the transform size (8 or 4 points) and whether the vector belongs to the first (row) pass or the second (column) pass of a separable 2-D transform. The matching rounding offset and right shift are applied to the result, so each output lane is ready for the next stage.

The arithmetic is split into an even half and an odd half, then combined in one final add/subtract butterfly. Every constant product is a sum of shifted copies of its operand, so the datapath contains no multiplier. The even half, the odd half and the butterfly are shared by all six transforms. A valid/ready handshake accepts one full vector per clock. Results appear two clock cycles later, and the whole pipeline stalls as one unit when the consumer holds off. The transpose storage between the row and column passes belongs to the surrounding decoder.

Top module: `multi_itx`

## Requirements
- R1: Mode fields: `i_std` 0 selects the H.264/AVC transform, 1 selects VC-1, 2 selects AVS, and 3 behaves exactly like 0. `i_four`=1 selects the 4-point size. `i_col`=1 marks a column-pass vector. Input lane k occupies `i_coef[k*IW +: IW]` and output lane n occupies `o_res[n*OW +: OW]`, both two's complement.
- R2: VC-1 8-point mode gives y[n] = sum over k of M[k][n]*x[k]. The rows of M are: row0 all a; row4 (a,-a,-a,a,a,-a,-a,a); row2 (b,c,-c,-b,-b,-c,c,b); row6 (c,-b,b,-c,-c,b,-b,c); row1 (d,e,f,g,-g,-f,-e,-d); row3 (e,-g,-d,-f,f,d,g,-e); row5 (f,-d,g,e,-e,-g,d,-f); row7 (g,-f,e,-d,d,-e,f,-g). The constants are a=12, b=16, c=6, d=16, e=15, f=9, g=4.
- R3: AVS 8-point mode uses the same matrix shape as R2 with a=8, b=10, c=4, d=10, e=9, f=6, g=2.
- R4: H.264/AVC 8-point mode is bit-exact to the standard's fast flow, with arithmetic right shifts. Even part: p0=x0+x4, p4=x0-x4, p2=(x2>>1)-x6, p6=x2+(x6>>1). Odd part: q1=-x3+x5-x7-(x7>>1), q3=x1+x7-x3-(x3>>1), q5=-x1+x7+x5+(x5>>1), q7=x3+x5+x1+(x1>>1). Outputs: y0/y7 = (p0+p6) ± (q7-(q1>>2)), y1/y6 = (p4+p2) ± ((q3>>2)-q5), y2/y5 = (p4-p2) ± (q3+(q5>>2)), y3/y4 = (p0-p6) ± (q1+(q7>>2)).
- R5: In 4-point mode only lanes 0..3 are read, and output lanes 4..7 are zero. H.264 uses y0/y3=(x0+x2) ± (x1+(x3>>1)) and y1/y2=(x0-x2) ± ((x1>>1)-x3). VC-1 and AVS use rows (a,a,a,a), (b,c,-c,-b), (a,-a,-a,a), (c,-b,b,-c), with (a,b,c)=(17,22,10) for VC-1 and (2,3,1) for AVS.
- R6: Each output lane is (v+off)>>>sh. For H.264 this is (0,0) on a row pass and (32,6) on a column pass. For VC-1 and AVS it is (4,3) on a row pass and (64,7) on a column pass.
- R7: A vector accepted at a clock edge appears on the outputs with `o_valid` high after the second following edge, provided the output was not stalled. Back-to-back vectors are accepted one per cycle.
- R8: While `o_valid` is high and `o_ready` is low, `o_res` and `o_valid` hold and `i_ready` is low.
- R9: During and right after reset, `o_valid` is low and `i_ready` is high.
- R10: Intermediate values are sign-extended, so full-scale inputs (all at +max, all at min, or mixed signs) give exact results with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Input vector present |
| i_ready | output | 1 | Block accepts a vector this cycle |
| i_std | input | 2 | Standard select (R1) |
| i_four | input | 1 | 1 = 4-point transform |
| i_col | input | 1 | 1 = column-pass rounding |
| i_coef | input | 8*IW | Eight coefficient lanes |
| o_valid | output | 1 | Result vector present |
| o_ready | input | 1 | Consumer accepts the result |
| o_res | output | 8*OW | Eight reconstructed lanes |

## Verification
The bound checker watches the handshake on every cycle. It checks that an idle output always leaves the input ready, that a stalled result holds still while new input is refused, that an accepted vector reaches the output two edges later, and that no result appears without an acceptance two cycles before. The numeric behaviour can only be shown by the bench scenarios: the per-standard matrices, the bit-exact shift truncation of the H.264 flow, the rounding per pass, the zeroed upper lanes in 4-point mode and the absence of overflow at full scale. The bench sweeps every standard code, both sizes and both passes over extreme and pseudo-random vectors, and compares each lane with a direct matrix product or with the standard's own equations.

// File: rtl/itx_pkg.sv
package itx_pkg;

    typedef enum logic [1:0] {
        STD_H264 = 2'd0,
        STD_VC1  = 2'd1,
        STD_AVS  = 2'd2,
        STD_ALT  = 2'd3
    } std_e;

    typedef struct packed {
        std_e std;
        logic four;
        logic col;
    } mode_t;

    localparam int WIDE_W = 48;
    typedef logic signed [WIDE_W-1:0] wide_t;

    // constant product built only from shifts and adds
    function automatic wide_t kmul(input wide_t x, input logic [4:0] k);
        case (k)
            5'd1:    kmul = x;
            5'd2:    kmul = x <<< 1;
            5'd3:    kmul = (x <<< 1) + x;
            5'd4:    kmul = x <<< 2;
            5'd6:    kmul = (x <<< 2) + (x <<< 1);
            5'd8:    kmul = x <<< 3;
            5'd9:    kmul = (x <<< 3) + x;
            5'd10:   kmul = (x <<< 3) + (x <<< 1);
            5'd12:   kmul = (x <<< 3) + (x <<< 2);
            5'd15:   kmul = (x <<< 4) - x;
            5'd16:   kmul = x <<< 4;
            5'd17:   kmul = (x <<< 4) + x;
            5'd22:   kmul = (x <<< 4) + (x <<< 2) + (x <<< 1);
            default: kmul = '0;
        endcase
    endfunction

    function automatic logic is_h264(input std_e s);
        return (s == STD_H264) || (s == STD_ALT);
    endfunction

endpackage

// File: rtl/itx_even.sv
module itx_even
    import itx_pkg::*;
#(
    parameter int IW = 16,
    parameter int AW = 24
) (
    input  logic [8*IW-1:0]       coef,
    input  mode_t                 mode,
    output logic [3:0][AW-1:0]    ev
);
    wide_t x [8];
    wide_t e [4];
    wide_t s, t, u, v;
    logic [4:0] ka, kb, kc;

    for (genvar g = 0; g < 8; g++) begin : g_ext
        assign x[g] = wide_t'($signed(coef[g*IW +: IW]));
    end

    always_comb begin
        s = '0; t = '0; u = '0; v = '0;
        ka = 5'd0; kb = 5'd0; kc = 5'd0;
        for (int i = 0; i < 4; i++) e[i] = '0;
        if (is_h264(mode.std)) begin
            if (mode.four) begin
                e[0] = x[0] + x[2];
                e[1] = x[0] - x[2];
            end else begin
                s = x[0] + x[4];
                t = x[0] - x[4];
                u = x[2] + (x[6] >>> 1);
                v = (x[2] >>> 1) - x[6];
                e[0] = s + u;
                e[1] = t + v;
                e[2] = t - v;
                e[3] = s - u;
            end
        end else begin
            if (mode.four) begin
                ka = (mode.std == STD_VC1) ? 5'd17 : 5'd2;
                e[0] = kmul(x[0] + x[2], ka);
                e[1] = kmul(x[0] - x[2], ka);
            end else begin
                ka = (mode.std == STD_VC1) ? 5'd12 : 5'd8;
                kb = (mode.std == STD_VC1) ? 5'd16 : 5'd10;
                kc = (mode.std == STD_VC1) ? 5'd6  : 5'd4;
                s = kmul(x[0] + x[4], ka);
                t = kmul(x[0] - x[4], ka);
                u = kmul(x[2], kb) + kmul(x[6], kc);
                v = kmul(x[2], kc) - kmul(x[6], kb);
                e[0] = s + u;
                e[1] = t + v;
                e[2] = t - v;
                e[3] = s - u;
            end
        end
        for (int i = 0; i < 4; i++) ev[i] = e[i][AW-1:0];
    end

endmodule

// File: rtl/itx_odd.sv
module itx_odd
    import itx_pkg::*;
#(
    parameter int IW = 16,
    parameter int AW = 24
) (
    input  logic [8*IW-1:0]       coef,
    input  mode_t                 mode,
    output logic [3:0][AW-1:0]    od
);
    wide_t x [8];
    wide_t o [4];
    wide_t q1, q3, q5, q7;
    logic [4:0] kd, ke, kf, kg;

    for (genvar g = 0; g < 8; g++) begin : g_ext
        assign x[g] = wide_t'($signed(coef[g*IW +: IW]));
    end

    always_comb begin
        q1 = '0; q3 = '0; q5 = '0; q7 = '0;
        kd = 5'd0; ke = 5'd0; kf = 5'd0; kg = 5'd0;
        for (int i = 0; i < 4; i++) o[i] = '0;
        if (is_h264(mode.std)) begin
            if (mode.four) begin
                o[0] = x[1] + (x[3] >>> 1);
                o[1] = (x[1] >>> 1) - x[3];
            end else begin
                q1 = x[5] - x[3] - x[7] - (x[7] >>> 1);
                q3 = x[1] + x[7] - x[3] - (x[3] >>> 1);
                q5 = x[7] - x[1] + x[5] + (x[5] >>> 1);
                q7 = x[3] + x[5] + x[1] + (x[1] >>> 1);
                o[0] = q7 - (q1 >>> 2);
                o[1] = (q3 >>> 2) - q5;
                o[2] = q3 + (q5 >>> 2);
                o[3] = q1 + (q7 >>> 2);
            end
        end else begin
            if (mode.four) begin
                kd = (mode.std == STD_VC1) ? 5'd22 : 5'd3;
                ke = (mode.std == STD_VC1) ? 5'd10 : 5'd1;
                o[0] = kmul(x[1], kd) + kmul(x[3], ke);
                o[1] = kmul(x[1], ke) - kmul(x[3], kd);
            end else begin
                kd = (mode.std == STD_VC1) ? 5'd16 : 5'd10;
                ke = (mode.std == STD_VC1) ? 5'd15 : 5'd9;
                kf = (mode.std == STD_VC1) ? 5'd9  : 5'd6;
                kg = (mode.std == STD_VC1) ? 5'd4  : 5'd2;
                o[0] = kmul(x[1], kd) + kmul(x[3], ke) + kmul(x[5], kf) + kmul(x[7], kg);
                o[1] = kmul(x[1], ke) - kmul(x[3], kg) - kmul(x[5], kd) - kmul(x[7], kf);
                o[2] = kmul(x[1], kf) - kmul(x[3], kd) + kmul(x[5], kg) + kmul(x[7], ke);
                o[3] = kmul(x[1], kg) - kmul(x[3], kf) + kmul(x[5], ke) - kmul(x[7], kd);
            end
        end
        for (int i = 0; i < 4; i++) od[i] = o[i][AW-1:0];
    end

endmodule

// File: rtl/itx_bfly.sv
module itx_bfly
    import itx_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [3:0][AW-1:0]    ev,
    input  logic [3:0][AW-1:0]    od,
    input  mode_t                 mode,
    output logic [7:0][AW-1:0]    y
);
    logic signed [AW-1:0] sm [4];
    logic signed [AW-1:0] df [4];
    logic signed [AW-1:0] rs [4];
    logic signed [AW-1:0] rd [4];
    logic signed [AW-1:0] off;
    logic [2:0]           sh;

    always_comb begin
        if (is_h264(mode.std)) begin
            off = mode.col ? AW'(32) : AW'(0);
            sh  = mode.col ? 3'd6 : 3'd0;
        end else begin
            off = mode.col ? AW'(64) : AW'(4);
            sh  = mode.col ? 3'd7 : 3'd3;
        end
        for (int i = 0; i < 4; i++) begin
            sm[i] = $signed(ev[i]) + $signed(od[i]);
            df[i] = $signed(ev[i]) - $signed(od[i]);
            rs[i] = (sm[i] + off) >>> sh;
            rd[i] = (df[i] + off) >>> sh;
        end
        y = '0;
        if (mode.four) begin
            y[0] = rs[0];
            y[1] = rs[1];
            y[2] = rd[1];
            y[3] = rd[0];
        end else begin
            for (int i = 0; i < 4; i++) begin
                y[i]   = rs[i];
                y[7-i] = rd[i];
            end
        end
    end

endmodule

// File: rtl/multi_itx.sv
module multi_itx
    import itx_pkg::*;
#(
    parameter int IW = 16,
    parameter int OW = IW + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_valid,
    output logic              i_ready,
    input  logic [1:0]        i_std,
    input  logic              i_four,
    input  logic              i_col,
    input  logic [8*IW-1:0]   i_coef,
    output logic              o_valid,
    input  logic              o_ready,
    output logic [8*OW-1:0]   o_res
);
    localparam int AW = OW;

    typedef struct packed {
        logic               s1_v;
        mode_t              s1_m;
        logic [3:0][AW-1:0] s1_e;
        logic [3:0][AW-1:0] s1_o;
        logic               out_v;
        logic [7:0][AW-1:0] out_y;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    mode_t in_mode;
    logic  advance;
    logic [3:0][AW-1:0] ev_w, od_w;
    logic [7:0][AW-1:0] y_w;

    assign in_mode = '{std: std_e'(i_std), four: i_four, col: i_col};

    itx_even #(.IW(IW), .AW(AW)) u_even (.coef(i_coef), .mode(in_mode), .ev(ev_w));
    itx_odd  #(.IW(IW), .AW(AW)) u_odd  (.coef(i_coef), .mode(in_mode), .od(od_w));
    itx_bfly #(.AW(AW)) u_bfly (
        .ev(pipe_q.s1_e), .od(pipe_q.s1_o), .mode(pipe_q.s1_m), .y(y_w)
    );

    always_comb begin
        pipe_d  = pipe_q;
        advance = !pipe_q.out_v || o_ready;
        if (advance) begin
            pipe_d.s1_v  = i_valid;
            pipe_d.out_v = pipe_q.s1_v;
            if (i_valid) begin
                pipe_d.s1_m = in_mode;
                pipe_d.s1_e = ev_w;
                pipe_d.s1_o = od_w;
            end
            if (pipe_q.s1_v) pipe_d.out_y = y_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign i_ready = advance;
    assign o_valid = pipe_q.out_v;
    assign o_res   = pipe_q.out_y;

endmodule

// File: rtl/itx_chk.sv
module itx_chk #(
    parameter int OW = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            i_valid,
    input logic            i_ready,
    input logic            o_valid,
    input logic            o_ready,
    input logic [8*OW-1:0] o_res
);
    // R9: an empty output stage never refuses input
    a_r9_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !o_valid |-> i_ready);

    // R8: stalled result holds its value and validity
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_res)));

    // R8: no acceptance while stalled
    a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |-> !i_ready);

    // R7: accepted vector emerges two edges later when not stalled
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_ready) ##1 o_ready |=> o_valid);

    // R7: no result without an acceptance two cycles earlier
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_valid) |-> $past(i_valid && i_ready, 2));
endmodule

bind multi_itx itx_chk #(.OW(OW)) u_itx_chk (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_ready(i_ready),
    .o_valid(o_valid), .o_ready(o_ready), .o_res(o_res)
);

// File: tb/tb_multi_itx.sv
module tb_multi_itx;
    localparam int IW = 16;
    localparam int OW = IW + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_valid = 1'b0;
    logic i_ready;
    logic [1:0] i_std = 2'd0;
    logic i_four = 1'b0;
    logic i_col = 1'b0;
    logic [8*IW-1:0] i_coef = '0;
    logic o_valid;
    logic o_ready = 1'b1;
    logic [8*OW-1:0] o_res;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int unsigned seed = 32'h1234_5678;

    multi_itx #(.IW(IW), .OW(OW)) dut (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_ready(i_ready),
        .i_std(i_std), .i_four(i_four), .i_col(i_col), .i_coef(i_coef),
        .o_valid(o_valid), .o_ready(o_ready), .o_res(o_res)
    );

    always #2.5 clk = ~clk;

    function automatic longint lane(input int n);
        return longint'($signed(o_res[n*OW +: OW]));
    endfunction

    function automatic longint rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return longint'($signed(seed[30:15]));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void ref_model(input int sd, input bit four, input bit col,
                                      input longint x[8], output longint y[8]);
        longint m[8][8];
        longint z[8];
        longint a, b, c, d, e, f, g, off;
        longint p0, p2, p4, p6, q1, q3, q5, q7;
        int sh;
        for (int n = 0; n < 8; n++) z[n] = 0;
        if (sd == 0 || sd == 3) begin
            if (four) begin
                z[0] = (x[0] + x[2]) + (x[1] + (x[3] >>> 1));
                z[3] = (x[0] + x[2]) - (x[1] + (x[3] >>> 1));
                z[1] = (x[0] - x[2]) + ((x[1] >>> 1) - x[3]);
                z[2] = (x[0] - x[2]) - ((x[1] >>> 1) - x[3]);
            end else begin
                p0 = x[0] + x[4]; p4 = x[0] - x[4];
                p2 = (x[2] >>> 1) - x[6]; p6 = x[2] + (x[6] >>> 1);
                q1 = -x[3] + x[5] - x[7] - (x[7] >>> 1);
                q3 = x[1] + x[7] - x[3] - (x[3] >>> 1);
                q5 = -x[1] + x[7] + x[5] + (x[5] >>> 1);
                q7 = x[3] + x[5] + x[1] + (x[1] >>> 1);
                z[0] = (p0 + p6) + (q7 - (q1 >>> 2));
                z[7] = (p0 + p6) - (q7 - (q1 >>> 2));
                z[1] = (p4 + p2) + ((q3 >>> 2) - q5);
                z[6] = (p4 + p2) - ((q3 >>> 2) - q5);
                z[2] = (p4 - p2) + (q3 + (q5 >>> 2));
                z[5] = (p4 - p2) - (q3 + (q5 >>> 2));
                z[3] = (p0 - p6) + (q1 + (q7 >>> 2));
                z[4] = (p0 - p6) - (q1 + (q7 >>> 2));
            end
        end else if (four) begin
            a = (sd == 1) ? 17 : 2; b = (sd == 1) ? 22 : 3; c = (sd == 1) ? 10 : 1;
            m[0][0:3] = '{a, a, a, a};
            m[1][0:3] = '{b, c, -c, -b};
            m[2][0:3] = '{a, -a, -a, a};
            m[3][0:3] = '{c, -b, b, -c};
            for (int n = 0; n < 4; n++)
                for (int k = 0; k < 4; k++) z[n] += m[k][n] * x[k];
        end else begin
            if (sd == 1) begin a = 12; b = 16; c = 6; d = 16; e = 15; f = 9; g = 4; end
            else         begin a = 8;  b = 10; c = 4; d = 10; e = 9;  f = 6; g = 2; end
            m[0] = '{a, a, a, a, a, a, a, a};
            m[4] = '{a, -a, -a, a, a, -a, -a, a};
            m[2] = '{b, c, -c, -b, -b, -c, c, b};
            m[6] = '{c, -b, b, -c, -c, b, -b, c};
            m[1] = '{d, e, f, g, -g, -f, -e, -d};
            m[3] = '{e, -g, -d, -f, f, d, g, -e};
            m[5] = '{f, -d, g, e, -e, -g, d, -f};
            m[7] = '{g, -f, e, -d, d, -e, f, -g};
            for (int n = 0; n < 8; n++)
                for (int k = 0; k < 8; k++) z[n] += m[k][n] * x[k];
        end
        if (sd == 0 || sd == 3) begin off = col ? 32 : 0; sh = col ? 6 : 0; end
        else                    begin off = col ? 64 : 4; sh = col ? 7 : 3; end
        for (int n = 0; n < 8; n++)
            y[n] = (four && n >= 4) ? 0 : ((z[n] + off) >>> sh);
    endfunction

    function automatic string tag_of(input int sd, input bit four);
        if (four) return (sd == 3) ? "R1/R5/R6" : "R5/R6";
        case (sd)
            0: return "R4/R6";
            1: return "R2/R6";
            2: return "R3/R6";
            default: return "R1/R4/R6";
        endcase
    endfunction

    task automatic drive(input int sd, input bit four, input bit col, input longint x[8]);
        i_std = sd[1:0]; i_four = four; i_col = col;
        for (int k = 0; k < 8; k++) i_coef[k*IW +: IW] = x[k][IW-1:0];
        i_valid = 1'b1;
    endtask

    task automatic run_vec(input int sd, input bit four, input bit col, input longint x[8]);
        longint y[8];
        string tg;
        ref_model(sd, four, col, x, y);
        tg = tag_of(sd, four);
        @(negedge clk);
        drive(sd, four, col, x);
        @(negedge clk);
        i_valid = 1'b0;
        check("R7 not yet valid", longint'(o_valid), 0);
        @(negedge clk);
        check("R7 valid at 2", longint'(o_valid), 1);
        for (int n = 0; n < 8; n++) check(tg, lane(n), y[n]);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        longint x[8];
        longint ya[6][8];
        longint xs[6][8];
        longint y[8];
        repeat (3) @(negedge clk);
        check("R9 reset o_valid", longint'(o_valid), 0);
        check("R9 reset i_ready", longint'(i_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset o_valid", longint'(o_valid), 0);
        check("R9 after reset i_ready", longint'(i_ready), 1);

        // sweep of every standard code, size and pass
        for (int sd = 0; sd < 4; sd++)
            for (int fz = 0; fz < 2; fz++)
                for (int cp = 0; cp < 2; cp++)
                    for (int v = 0; v < 12; v++) begin
                        for (int k = 0; k < 8; k++) begin
                            case (v)
                                0: x[k] = 32767;                       // R10
                                1: x[k] = -32768;                      // R10
                                2: x[k] = k[0] ? -32768 : 32767;       // R10
                                3: x[k] = (k[0] ^ k[1]) ? -32768 : 32767;
                                default: x[k] = rnd16();
                            endcase
                        end
                        run_vec(sd, fz[0], cp[0], x);
                    end

        // R7 back-to-back stream, one vector per cycle
        for (int i = 0; i < 6; i++) begin
            for (int k = 0; k < 8; k++) xs[i][k] = rnd16();
            ref_model(1, 1'b0, 1'b1, xs[i], y);
            ya[i] = y;
        end
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                check("R7 stream valid", longint'(o_valid), 1);
                for (int n = 0; n < 8; n++) check("R7 stream data", lane(n), ya[c-2][n]);
            end
            if (c < 6) begin
                check("R7 stream ready", longint'(i_ready), 1);
                drive(1, 1'b0, 1'b1, xs[c]);
            end else i_valid = 1'b0;
        end

        // R8 backpressure
        for (int i = 0; i < 2; i++) begin
            for (int k = 0; k < 8; k++) xs[i][k] = rnd16();
            ref_model(2, 1'b0, 1'b0, xs[i], y);
            ya[i] = y;
        end
        @(negedge clk);
        o_ready = 1'b0;
        drive(2, 1'b0, 1'b0, xs[0]);
        @(negedge clk);
        drive(2, 1'b0, 1'b0, xs[1]);
        @(negedge clk);
        for (int h = 0; h < 3; h++) begin
            check("R8 held valid", longint'(o_valid), 1);
            check("R8 input refused", longint'(i_ready), 0);
            for (int n = 0; n < 8; n++) check("R8 held data", lane(n), ya[0][n]);
            @(negedge clk);
        end
        o_ready = 1'b1;
        i_valid = 1'b0;
        @(negedge clk);
        check("R8 second valid", longint'(o_valid), 1);
        for (int n = 0; n < 8; n++) check("R8 second data", lane(n), ya[1][n]);
        @(negedge clk);
        check("R8 drained", longint'(o_valid), 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule